// File: doc/BRIEF.md
# Dual-Group Vectored Interrupt Controller

This block gathers interrupt events from eight receive channels and three transmit channels and presents them to a host processor as two separate active-low request lines, one per group. Each event sets a pending bit for its channel. A per-channel mask decides whether that pending bit may raise the group's request line and compete for service. Each group sits in its own priority daisy chain. A group passes the chain grant downstream only when it has nothing unmasked pending.

During a single-cycle acknowledge addressed to one group, the block returns an 8-bit vector in that same cycle. The vector is formed from a host-written 4-bit base in the upper nibble and the code of the winning channel in the lower nibble. The winner's pending bit is cleared at the clock edge that closes the acknowledge. Among transmit channels the lowest index wins. Among receive channels the winner comes from an ordered list of eight priority slots that the host can rewrite.

Registers are reached through a plain synchronous port. Writes take effect at the clock edge. Read data is a combinational function of the address.

Top module: `dual_chain_irq`

## Requirements
- R1: After reset, all pending bits and all mask bits are 0, the vector base is 0, and priority slot i holds receive channel i. Both request lines are high, and each chain output equals its chain input.
- R2: An event input that is high at a clock edge sets that channel's pending bit from that edge onward. Pending bits are read at address 3: receive channel n is at bit n, and transmit channel m is at bit 8+m.
- R3: `rx_irq_n` is low exactly when at least one receive channel is pending and unmasked. `tx_irq_n` follows the same rule for the transmit channels.
- R4: A group's chain output is high only when its chain input is high and the group has no unmasked pending channel.
- R5: When `iack` is high, the group chosen by `iack_grp` (0 = receive, 1 = transmit) has its chain input high and has an unmasked pending channel, `vec_valid` is high in that cycle. `vec_out` is then {base, code}, where receive channel n has code n and transmit channel m has code 8+m.
- R6: If an acknowledge finds the chosen group's chain input low, or finds no unmasked pending channel in that group, then `vec_valid` and `vec_out` are 0 and no pending bit changes.
- R7: The receive winner is the channel named in the lowest-numbered slot whose channel is unmasked and pending. The priority register is at address 2, and slot s occupies bits 3s+2 down to 3s.
- R8: Among unmasked pending transmit channels, the lowest index wins.
- R9: A returned vector clears the winner's pending bit at the closing edge. If an event for that same channel arrives in the same cycle, the bit stays set.
- R10: A set mask bit stops its channel from driving the request line and from winning arbitration, but the channel's pending bit is kept. The mask register is at address 0 and uses the same bit positions as the pending register.
- R11: The vector base is held in bits 3:0 at address 1. Writes to address 3 are ignored. Unused read bits return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_event | input | 8 | Receive channel event strobes |
| tx_event | input | 3 | Transmit channel event strobes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rx_irq_n | output | 1 | Receive group request, active low |
| tx_irq_n | output | 1 | Transmit group request, active low |
| rx_chain_in | input | 1 | Receive group daisy-chain input |
| rx_chain_out | output | 1 | Receive group daisy-chain output |
| tx_chain_in | input | 1 | Transmit group daisy-chain input |
| tx_chain_out | output | 1 | Transmit group daisy-chain output |
| iack | input | 1 | Single-cycle acknowledge |
| iack_grp | input | 1 | Acknowledged group: 0 receive, 1 transmit |
| vec_out | output | 8 | Returned vector |
| vec_valid | output | 1 | Vector valid in this cycle |

## Verification
Request lines, chain outputs, `vec_valid`, `vec_out` and read data are combinational. They are due in the same cycle as the inputs that cause them, so the bench drives inputs just after a falling edge and samples a few nanoseconds later, before the next rising edge. Pending bits, mask, base and priority change at the rising edge that closes an event pulse, a write or an acknowledge. Their effects are therefore sampled only from the following falling edge onward. Priority is checked by draining a full set of pending channels one acknowledge per cycle under several slot orders, and the expected order is computed in the bench from the slot contents.

// File: rtl/dci_pkg.sv
package dci_pkg;
    localparam int RX_N   = 8;
    localparam int TX_N   = 3;
    localparam int CH_N   = RX_N + TX_N;
    localparam int SLOT_W = $clog2(RX_N);
    localparam int CODE_W = 4;
    localparam int VEC_W  = 8;
    localparam int BASE_W = VEC_W - CODE_W;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK = 2'd0,
        A_BASE = 2'd1,
        A_PRIO = 2'd2,
        A_PEND = 2'd3
    } reg_addr_e;

    typedef logic [RX_N-1:0][SLOT_W-1:0] prio_t;

    typedef struct packed {
        logic              hit;
        logic [CODE_W-1:0] code;
    } grant_t;

    function automatic prio_t identity_prio();
        prio_t p;
        for (int i = 0; i < RX_N; i++) p[i] = SLOT_W'(i);
        return p;
    endfunction

    function automatic logic [VEC_W-1:0] make_vec(logic [BASE_W-1:0] base,
                                                  logic [CODE_W-1:0] code);
        return {base, code};
    endfunction
endpackage

// File: rtl/dci_regs.sv
module dci_regs
    import dci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CH_N-1:0]   pend,
    output logic [CH_N-1:0]   mask,
    output logic [BASE_W-1:0] base,
    output prio_t             prio,
    output logic [DATA_W-1:0] rdata
);
    localparam int PRIO_BITS = RX_N * SLOT_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            base <= '0;
            prio <= identity_prio();
        end else if (wr) begin
            case (reg_addr_e'(addr))
                A_MASK:  mask <= wdata[CH_N-1:0];
                A_BASE:  base <= wdata[BASE_W-1:0];
                A_PRIO:  prio <= prio_t'(wdata[PRIO_BITS-1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            A_MASK: rdata[CH_N-1:0]      = mask;
            A_BASE: rdata[BASE_W-1:0]    = base;
            A_PRIO: rdata[PRIO_BITS-1:0] = prio;
            A_PEND: rdata[CH_N-1:0]      = pend;
            default: ;
        endcase
    end
endmodule

// File: rtl/dci_pending.sv
module dci_pending
    import dci_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [CH_N-1:0] set,
    input  logic [CH_N-1:0] clr,
    output logic [CH_N-1:0] pend
);
    for (genvar i = 0; i < CH_N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend[i] <= 1'b0;
            else
                pend[i] <= set[i] | (pend[i] & ~clr[i]);
        end
    end
endmodule

// File: rtl/dci_rx_arb.sv
module dci_rx_arb
    import dci_pkg::*;
(
    input  logic [RX_N-1:0] active,
    input  prio_t           prio,
    output grant_t          grant
);
    always_comb begin
        grant = '0;
        for (int s = RX_N - 1; s >= 0; s--) begin
            if (active[prio[s]]) begin
                grant.hit  = 1'b1;
                grant.code = CODE_W'(prio[s]);
            end
        end
    end
endmodule

// File: rtl/dci_tx_arb.sv
module dci_tx_arb
    import dci_pkg::*;
(
    input  logic [TX_N-1:0] active,
    output grant_t          grant
);
    always_comb begin
        grant = '0;
        for (int t = TX_N - 1; t >= 0; t--) begin
            if (active[t]) begin
                grant.hit  = 1'b1;
                grant.code = CODE_W'(RX_N + t);
            end
        end
    end
endmodule

// File: rtl/dual_chain_irq.sv
module dual_chain_irq
    import dci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RX_N-1:0]   rx_event,
    input  logic [TX_N-1:0]   tx_event,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              rx_irq_n,
    output logic              tx_irq_n,
    input  logic              rx_chain_in,
    output logic              rx_chain_out,
    input  logic              tx_chain_in,
    output logic              tx_chain_out,
    input  logic              iack,
    input  logic              iack_grp,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_valid
);
    logic [CH_N-1:0]   pend;
    logic [CH_N-1:0]   mask;
    logic [CH_N-1:0]   active;
    logic [CH_N-1:0]   clr;
    logic [BASE_W-1:0] base;
    prio_t             prio;
    grant_t            rx_g, tx_g, win;
    logic              rx_any, tx_any, ack_rx, ack_tx;

    dci_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .pend(pend), .mask(mask), .base(base), .prio(prio), .rdata(reg_rdata)
    );

    dci_pending u_pend (
        .clk(clk), .rst(rst), .set({tx_event, rx_event}), .clr(clr), .pend(pend)
    );

    assign active = pend & ~mask;
    assign rx_any = |active[RX_N-1:0];
    assign tx_any = |active[CH_N-1:RX_N];

    dci_rx_arb u_rx_arb (.active(active[RX_N-1:0]), .prio(prio), .grant(rx_g));
    dci_tx_arb u_tx_arb (.active(active[CH_N-1:RX_N]), .grant(tx_g));

    assign rx_irq_n     = ~rx_any;
    assign tx_irq_n     = ~tx_any;
    assign rx_chain_out = rx_chain_in & ~rx_any;
    assign tx_chain_out = tx_chain_in & ~tx_any;

    assign ack_rx    = iack & ~iack_grp & rx_chain_in & rx_g.hit;
    assign ack_tx    = iack &  iack_grp & tx_chain_in & tx_g.hit;
    assign vec_valid = ack_rx | ack_tx;
    assign win       = iack_grp ? tx_g : rx_g;
    assign vec_out   = vec_valid ? make_vec(base, win.code) : '0;

    always_comb begin
        clr = '0;
        if (vec_valid) clr[win.code] = 1'b1;
    end
endmodule

// File: rtl/dci_checker.sv
module dci_checker
    import dci_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [RX_N-1:0]   rx_event,
    input logic [TX_N-1:0]   tx_event,
    input logic [CH_N-1:0]   pend,
    input logic [CH_N-1:0]   mask,
    input logic              rx_irq_n,
    input logic              tx_irq_n,
    input logic              rx_chain_in,
    input logic              rx_chain_out,
    input logic              tx_chain_in,
    input logic              tx_chain_out,
    input logic              iack,
    input logic [VEC_W-1:0]  vec_out,
    input logic              vec_valid
);
    localparam int FULL = 2 ** CODE_W;
    logic [FULL-1:0]   evt_all, pend_all, mask_all;
    logic [CODE_W-1:0] code;

    assign evt_all  = FULL'({tx_event, rx_event});
    assign pend_all = FULL'(pend);
    assign mask_all = FULL'(mask);
    assign code     = vec_out[CODE_W-1:0];

    // R1
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (pend == '0 && mask == '0));

    // R2
    p_event_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (|rx_event) |=> ((pend[RX_N-1:0] & $past(rx_event)) == $past(rx_event)));

    // R4
    p_rx_chain_r4: assert property (@(posedge clk) disable iff (rst)
        rx_chain_out |-> (rx_chain_in && rx_irq_n));
    p_tx_chain_r4: assert property (@(posedge clk) disable iff (rst)
        tx_chain_out |-> (tx_chain_in && tx_irq_n));

    // R5
    p_valid_needs_ack_r5: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> iack);

    // R9
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !evt_all[code]) |=> !pend_all[$past(code)]);

    // R10
    p_masked_never_wins_r10: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (!mask_all[code] && pend_all[code]));
endmodule

bind dual_chain_irq dci_checker i_chk (
    .clk(clk), .rst(rst), .rx_event(rx_event), .tx_event(tx_event),
    .pend(pend), .mask(mask), .rx_irq_n(rx_irq_n), .tx_irq_n(tx_irq_n),
    .rx_chain_in(rx_chain_in), .rx_chain_out(rx_chain_out),
    .tx_chain_in(tx_chain_in), .tx_chain_out(tx_chain_out),
    .iack(iack), .vec_out(vec_out), .vec_valid(vec_valid)
);

// File: tb/test_dual_chain_irq.sv
module test_dual_chain_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_event = '0;
    logic [2:0]  tx_event = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_irq_n, tx_irq_n, rx_chain_out, tx_chain_out, vec_valid;
    logic        rx_chain_in = 1'b1, tx_chain_in = 1'b1;
    logic        iack = 1'b0, iack_grp = 1'b0;
    logic [7:0]  vec_out;

    int n_chk = 0;
    int n_err = 0;
    localparam logic [3:0] BASE = 4'hA;

    always #10 clk = ~clk;

    dual_chain_irq i_dual_chain_irq (
        .clk(clk), .rst(rst), .rx_event(rx_event), .tx_event(tx_event),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_irq_n(rx_irq_n), .tx_irq_n(tx_irq_n),
        .rx_chain_in(rx_chain_in), .rx_chain_out(rx_chain_out),
        .tx_chain_in(tx_chain_in), .tx_chain_out(tx_chain_out),
        .iack(iack), .iack_grp(iack_grp), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(string req, logic [1:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #2 chk(req, reg_rdata, exp);
    endtask

    task automatic pulse(logic [7:0] rxe, logic [2:0] txe);
        @(negedge clk);
        rx_event = rxe; tx_event = txe;
        @(posedge clk); #1;
        rx_event = '0; tx_event = '0;
    endtask

    task automatic ack(string req, logic grp, logic [7:0] rxe, logic ok, logic [3:0] code);
        @(negedge clk);
        iack = 1'b1; iack_grp = grp; rx_event = rxe;
        #2;
        chk(req, {31'd0, vec_valid}, {31'd0, ok});
        chk(req, {24'd0, vec_out}, ok ? {24'd0, BASE, code} : 32'd0);
        @(posedge clk); #1;
        iack = 1'b0; rx_event = '0;
    endtask

    task automatic lines(string req, logic rxi, logic txi, logic rxc, logic txc);
        @(negedge clk); #2;
        chk(req, {28'd0, rx_irq_n, tx_irq_n, rx_chain_out, tx_chain_out},
                 {28'd0, rxi, txi, rxc, txc});
    endtask

    function automatic logic [31:0] pack_prio(int rot, bit rev);
        logic [31:0] v = '0;
        for (int s = 0; s < 8; s++) begin
            int ch = rev ? 7 - s : (s + rot) % 8;
            v[3*s +: 3] = 3'(ch);
        end
        return v;
    endfunction

    initial begin
        #(20 * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        lines("R1 lines", 1, 1, 1, 1);
        rd("R1 mask", 2'd0, 0);
        rd("R1 base", 2'd1, 0);
        rd("R1 prio", 2'd2, pack_prio(0, 0));
        rd("R1 pend", 2'd3, 0);

        wr(2'd1, 32'hFFFF_FFF0 | BASE);
        rd("R11 base", 2'd1, {28'd0, BASE});

        // each receive channel alone: R2 R3 R4 R5 R9
        for (int c = 0; c < 8; c++) begin
            pulse(8'(1 << c), 3'd0);
            rd("R2 rx pend", 2'd3, 32'(1 << c));
            lines("R3 R4 rx asserted", 0, 1, 0, 1);
            ack("R5 rx vector", 1'b0, 8'd0, 1, 4'(c));
            rd("R9 rx cleared", 2'd3, 0);
            lines("R3 rx released", 1, 1, 1, 1);
        end

        // each transmit channel alone
        for (int t = 0; t < 3; t++) begin
            pulse(8'd0, 3'(1 << t));
            rd("R2 tx pend", 2'd3, 32'(1 << (8 + t)));
            lines("R3 R4 tx asserted", 1, 0, 1, 0);
            ack("R6 wrong group", 1'b0, 8'd0, 0, 4'd0);
            ack("R5 tx vector", 1'b1, 8'd0, 1, 4'(8 + t));
            rd("R9 tx cleared", 2'd3, 0);
        end

        // R7 priority orders
        wr(2'd2, pack_prio(0, 1));
        rd("R7 prio readback", 2'd2, pack_prio(0, 1));
        pulse(8'hFF, 3'd0);
        for (int k = 0; k < 8; k++) ack("R7 reversed order", 1'b0, 8'd0, 1, 4'(7 - k));
        for (int rot = 3; rot < 8; rot += 4) begin
            wr(2'd2, pack_prio(rot, 0));
            pulse(8'hFF, 3'd0);
            for (int k = 0; k < 8; k++) ack("R7 rotated order", 1'b0, 8'd0, 1, 4'((k + rot) % 8));
        end
        ack("R6 empty group", 1'b0, 8'd0, 0, 4'd0);
        wr(2'd2, pack_prio(0, 0));

        // R8 fixed transmit order
        pulse(8'd0, 3'b111);
        for (int k = 0; k < 3; k++) ack("R8 tx order", 1'b1, 8'd0, 1, 4'(8 + k));

        // R10 masking
        wr(2'd0, 32'h0000_0004);
        rd("R10 mask readback", 2'd0, 32'h4);
        pulse(8'h24, 3'd0);
        ack("R10 masked skipped", 1'b0, 8'd0, 1, 4'd5);
        lines("R10 masked no request", 1, 1, 1, 1);
        ack("R10 masked no vector", 1'b0, 8'd0, 0, 4'd0);
        rd("R10 pend kept", 2'd3, 32'h4);
        wr(2'd0, 32'h0000_0100);
        lines("R10 unmasked request", 0, 1, 0, 1);
        ack("R10 unmasked wins", 1'b0, 8'd0, 1, 4'd2);
        pulse(8'd0, 3'b001);
        lines("R10 tx masked", 1, 1, 1, 1);
        wr(2'd0, 32'd0);
        lines("R10 tx unmasked", 1, 0, 1, 0);
        ack("R10 tx vector", 1'b1, 8'd0, 1, 4'd8);

        // R6 chain input low
        pulse(8'h01, 3'd0);
        rx_chain_in = 1'b0;
        lines("R4 chain blocked", 0, 1, 0, 1);
        ack("R6 chain low", 1'b0, 8'd0, 0, 4'd0);
        rd("R6 pend unchanged", 2'd3, 32'h1);
        rx_chain_in = 1'b1;
        ack("R5 after chain high", 1'b0, 8'd0, 1, 4'd0);

        // R9 event in acknowledge cycle
        pulse(8'h08, 3'd0);
        ack("R9 same-cycle ack", 1'b0, 8'h08, 1, 4'd3);
        rd("R9 re-set", 2'd3, 32'h8);
        ack("R9 second ack", 1'b0, 8'd0, 1, 4'd3);

        // R11 register details
        wr(2'd3, 32'h0000_07FF);
        rd("R11 pend write ignored", 2'd3, 0);
        wr(2'd0, 32'hFFFF_FFFF);
        rd("R11 mask width", 2'd0, 32'h7FF);
        wr(2'd0, 32'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule